// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Unit

This block is a purely combinational arithmetic unit of configurable width. A single ripple-carry adder produces every result. Its first operand is always the word `A`. Its second operand comes from a per-bit four-way selector, which picks the word `B`, the bitwise inverse of `B`, a word of zeros or a word of ones. A carry-in then completes the operation.

The two-bit operand code and the carry-in together select one of eight microoperations. These are addition with or without a carry, subtraction with or without a borrow, increment, decrement, and pass-through of `A`. A datapath controller drives these fields directly and takes the result word together with the carry that leaves the top stage.

Top module: `sel_arith_unit`

## Requirements
- R1: With operand code 2'b00 (use B) and carry-in 0, `d_o` equals (A + B) mod 2^W and `cout_o` is 1 exactly when A + B is at least 2^W.
- R2: With operand code 2'b00 and carry-in 1, `d_o` equals (A + B + 1) mod 2^W and `cout_o` is 1 exactly when A + B + 1 is at least 2^W.
- R3: With operand code 2'b01 (use inverted B) and carry-in 0, `d_o` equals (A - B - 1) mod 2^W and `cout_o` is 1 exactly when A > B.
- R4: With operand code 2'b01 and carry-in 1, `d_o` equals (A - B) mod 2^W and `cout_o` is 1 exactly when A >= B.
- R5: With operand code 2'b10 (use zeros) and carry-in 0, `d_o` equals A, `cout_o` is 0, and B has no effect.
- R6: With operand code 2'b10 and carry-in 1, `d_o` equals (A + 1) mod 2^W and `cout_o` is 1 only when A is all ones.
- R7: With operand code 2'b11 (use ones across all W bits) and carry-in 0, `d_o` equals (A - 1) mod 2^W and `cout_o` is 1 exactly when A is nonzero.
- R8: With operand code 2'b11 and carry-in 1, `d_o` equals A and `cout_o` is 1, whatever B is.
- R9: The width W is a parameter (default 4). In every mode, `{cout_o, d_o}` is the full (W+1)-bit sum, so a carry ripples correctly from bit 0 to the top bit at any width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First adder operand, always used as is |
| b_i | input | WIDTH | Source word for the second operand |
| sel_i | input | 2 | Operand code: 00 B, 01 inverted B, 10 zeros, 11 ones |
| cin_i | input | 1 | Carry into bit 0 |
| d_o | output | WIDTH | Result word |
| cout_o | output | 1 | Carry out of the top stage |

## Verification
The bench builds one instance at the default width of 4. At that width it sweeps every combination of A, B, operand code and carry-in, which reaches every carry boundary, every wrap and every equality case exhaustively. A second instance at width 9 receives directed corner words, such as all ones, zero, one and alternating bits. These confirm that the ones operand spans the full width and that a carry ripples through more than a nibble.

// File: rtl/sel_arith_pkg.sv
// Package: shared encodings for the selectable-operand arithmetic unit.
// Assumes: the operand code is two bits wide and its values are fixed by the datapath controller.
package sel_arith_pkg;

    // Second-operand source selected per bit
    typedef enum logic [1:0] {
        OPND_B    = 2'b00,
        OPND_BINV = 2'b01,
        OPND_ZERO = 2'b10,
        OPND_ONES = 2'b11
    } opnd_sel_e;

endpackage

// File: rtl/opnd_mux.sv
// Module: opnd_mux
// Builds the second adder operand. Each bit has its own four-way selector
// that picks B, inverted B, zero or one.
// Assumes: sel_i is a legal opnd_sel_e code; all four codes are defined.
module opnd_mux
    import sel_arith_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_i,
    input  opnd_sel_e        sel_i,
    output logic [WIDTH-1:0] y_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Per-bit four-way operand selection
        always_comb begin
            unique case (sel_i)
                OPND_B:    y_o[g] = b_i[g];
                OPND_BINV: y_o[g] = ~b_i[g];
                OPND_ZERO: y_o[g] = 1'b0;
                OPND_ONES: y_o[g] = 1'b1;
                default:   y_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fa_cell.sv
// Module: fa_cell
// Single-bit full adder: adds three bits and gives a sum bit and a carry bit.
// Assumes: nothing beyond valid logic levels on its inputs.
module fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    // Sum and majority carry
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
    end

endmodule

// File: rtl/ripple_adder.sv
// Module: ripple_adder
// A chain of WIDTH full-adder cells. The carry of stage i feeds stage i+1,
// and the last carry is brought out.
// Assumes: WIDTH >= 1.
module ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int NCARRY = WIDTH + 1;

    logic [NCARRY-1:0] carry;

    // Inject the carry-in at the bottom of the chain
    assign carry[0] = cin_i;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        fa_cell u_fa (
            .x_i (x_i[g]),
            .y_i (y_i[g]),
            .c_i (carry[g]),
            .s_o (sum_o[g]),
            .c_o (carry[g+1])
        );
    end

    // Carry leaving the top stage
    assign cout_o = carry[NCARRY-1];

endmodule

// File: rtl/sel_arith_unit.sv
// Module: sel_arith_unit (top)
// Combinational arithmetic unit. It feeds A and a selected second operand
// (B, inverted B, zeros, ones) into one ripple-carry adder with a carry-in,
// which gives add, subtract, increment, decrement and transfer.
// Assumes: the caller registers inputs and outputs. The block has no state
// and therefore no clock or reset.
module sel_arith_unit
    import sel_arith_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] d_o,
    output logic             cout_o
);

    opnd_sel_e        sel_code;
    logic [WIDTH-1:0] opnd_y;

    // Interpret the raw code as the operand-source enum
    assign sel_code = opnd_sel_e'(sel_i);

    opnd_mux #(.WIDTH(WIDTH)) u_mux (
        .b_i   (b_i),
        .sel_i (sel_code),
        .y_o   (opnd_y)
    );

    ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x_i    (a_i),
        .y_i    (opnd_y),
        .cin_i  (cin_i),
        .sum_o  (d_o),
        .cout_o (cout_o)
    );

endmodule

// File: rtl/sel_arith_unit_chk.sv
// Module: sel_arith_unit_chk
// Checker bound to sel_arith_unit. Immediate assertions compare the result
// port with the arithmetic meaning of each operand code and carry-in.
// Assumes: the inputs are stable when the combinational process settles.
module sel_arith_unit_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [1:0]       sel_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] d_o,
    input logic             cout_o
);

    localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

    logic [WIDTH:0] ext_a;
    logic [WIDTH:0] ext_b;
    logic [WIDTH:0] ext_c;

    // Widened operands for the full-sum comparisons
    assign ext_a = {1'b0, a_i};
    assign ext_b = {1'b0, b_i};
    assign ext_c = {{WIDTH{1'b0}}, cin_i};

    // Check each operand code against its arithmetic meaning
    always_comb begin
        if (!$isunknown({a_i, b_i, sel_i, cin_i})) begin
            if (sel_i == 2'b00) begin
                assert_add_sum_R1: assert ({cout_o, d_o} == ext_a + ext_b + ext_c)
                    else $error("R1/R2 add mismatch");
            end
            if (sel_i == 2'b01 && cin_i) begin
                assert_sub_carry_R4: assert (cout_o == (a_i >= b_i))
                    else $error("R4 subtract carry mismatch");
            end
            if (sel_i == 2'b10 && !cin_i) begin
                assert_pass_zero_R5: assert (d_o == a_i && !cout_o)
                    else $error("R5 transfer mismatch");
            end
            if (sel_i == 2'b11 && cin_i) begin
                assert_pass_ones_R8: assert (d_o == a_i && cout_o)
                    else $error("R8 transfer mismatch");
            end
            if (sel_i == 2'b11 && !cin_i) begin
                assert_dec_carry_R7: assert (cout_o == (a_i != '0))
                    else $error("R7 decrement carry mismatch");
            end
            if (sel_i == 2'b10 && cin_i) begin
                assert_inc_wrap_R6: assert (cout_o == (a_i == ALL1))
                    else $error("R6 increment carry mismatch");
            end
        end
    end

endmodule

bind sel_arith_unit sel_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sel_i  (sel_i),
    .cin_i  (cin_i),
    .d_o    (d_o),
    .cout_o (cout_o)
);

// File: tb/sel_arith_unit_tb_top.sv
// Bench: directed scenarios, one task each, against two widths of the unit.
module sel_arith_unit_tb_top;

    localparam int W  = 4;
    localparam int WW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    logic [W-1:0]  a, b, d;
    logic [1:0]    sel;
    logic          cin, cout;
    logic [WW-1:0] wa, wb, wd;
    logic [1:0]    wsel;
    logic          wcin, wcout;

    sel_arith_unit #(.WIDTH(W)) dut_i (
        .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin), .d_o(d), .cout_o(cout)
    );

    sel_arith_unit #(.WIDTH(WW)) dut_wide_i (
        .a_i(wa), .b_i(wb), .sel_i(wsel), .cin_i(wcin), .d_o(wd), .cout_o(wcout)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic check(string req, longint act_d, longint exp_d, bit act_c, bit exp_c);
        n_checks++;
        if (act_d != exp_d || act_c != exp_c) begin
            n_errors++;
            $display("FAIL %s: actual d=%0d c=%0d expected d=%0d c=%0d",
                     req, act_d, act_c, exp_d, exp_c);
        end
    endtask

    task automatic drive(logic [W-1:0] av, logic [W-1:0] bv, logic [1:0] sv, logic cv);
        @(negedge clk);
        a = av; b = bv; sel = sv; cin = cv;
        #1;
    endtask

    // Exhaustive sweep of one operand code and carry-in at width W
    task automatic sweep_mode(logic [1:0] sv, logic cv);
        longint m = 1 << W;
        for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
                longint ed; bit ec;
                string  tag;
                drive(W'(ia), W'(ib), sv, cv);
                case ({sv, cv})
                    3'b000: begin tag = "R1"; ed = (ia + ib) % m;          ec = (ia + ib) >= m;     end
                    3'b001: begin tag = "R2"; ed = (ia + ib + 1) % m;      ec = (ia + ib + 1) >= m; end
                    3'b010: begin tag = "R3"; ed = (ia - ib - 1 + m) % m;  ec = ia > ib;            end
                    3'b011: begin tag = "R4"; ed = (ia - ib + m) % m;      ec = ia >= ib;           end
                    3'b100: begin tag = "R5"; ed = ia;                     ec = 1'b0;               end
                    3'b101: begin tag = "R6"; ed = (ia + 1) % m;           ec = ia == m - 1;        end
                    3'b110: begin tag = "R7"; ed = (ia - 1 + m) % m;       ec = ia != 0;            end
                    default: begin tag = "R8"; ed = ia;                    ec = 1'b1;               end
                endcase
                check(tag, longint'(d), ed, cout, ec);
            end
        end
    endtask

    // Reset-time state: zero inputs in add mode give a zero result
    task automatic test_idle_state();
        drive('0, '0, 2'b00, 1'b0);
        check("R1 idle", longint'(d), 0, cout, 1'b0);
    endtask

    // R9: wide instance, carry across all bits and ones operand at full width
    task automatic test_wide_corners();
        longint m = 1 << WW;
        logic [WW-1:0] pats[5] = '{'0, 9'd1, {WW{1'b1}}, 9'h155, 9'h0AA};
        foreach (pats[i]) begin
            foreach (pats[j]) begin
                for (int c = 0; c < 2; c++) begin
                    for (int s = 0; s < 4; s++) begin
                        longint ia = longint'(pats[i]);
                        longint ib = longint'(pats[j]);
                        longint opnd;
                        longint full;
                        @(negedge clk);
                        wa = pats[i]; wb = pats[j]; wsel = 2'(s); wcin = c[0];
                        #1;
                        case (s)
                            0: opnd = ib;
                            1: opnd = m - 1 - ib;
                            2: opnd = 0;
                            default: opnd = m - 1;
                        endcase
                        full = ia + opnd + c;
                        check("R9 wide", longint'(wd), full % m, wcout, full >= m);
                    end
                end
            end
        end
    endtask

    initial begin
        a = '0; b = '0; sel = '0; cin = 1'b0;
        wa = '0; wb = '0; wsel = '0; wcin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_idle_state();
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                sweep_mode(2'(s), c[0]);
            end
        end
        test_wide_corners();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule